// File: doc/BRIEF.md
# Triple-Phase SRAM Time-Slice Scheduler

This block sits between a CPU core, one single-port synchronous SRAM and a secondary reader such as a display refresh engine. The fast clock runs at up to three times the rated CPU frequency. The block splits every CPU T state into three fast-clock phases.

The scheduler holds the core's wait input high for the first two phases and releases it in the third, so the core advances once per triple. The first phase serves a video read. The second phase issues the CPU read, because the CPU address has settled by then. The third phase issues a CPU write. The SRAM therefore needs only one port, and the video reader never delays the CPU.

When the fast clock is no faster than the rated CPU frequency, a static bypass input turns the schedule off. In bypass, the CPU drives the SRAM directly and wait stays low.

The SRAM is modelled with a one-cycle read latency: the address and strobes are registered at a clock edge, and the data appears on `sramRdData` during the following cycle.

Top module: `tri_phase_sram_sched`

## Requirements
- R1: A phase counter steps 0, 1, 2, 0, ... once per clock and is forced to 0 by reset. The first cycle after reset release is phase 0.
- R2: With bypass low, `cpuWait` is 1 in phases 0 and 1 and 0 in phase 2.
- R3: With bypass low, in phase 0 `sramAddr` equals `vidAddr`, `sramCe` equals `vidReq`, and `sramWe` is 0.
- R4: With bypass low, in phase 1 `sramAddr` equals `cpuAddr`, `sramCe` equals `cpuRead`, and `sramWe` is 0.
- R5: With bypass low, in phase 2 `sramAddr` equals `cpuAddr` and both `sramCe` and `sramWe` equal `cpuWrite`. `sramWe` is never 1 in phase 0 or 1. `sramWrData` always equals `cpuDataOut`.
- R6: After a phase-0 video request, `vidValid` is 1 for exactly one cycle, in the next phase 2. In that cycle `vidData` shows the SRAM data returned during phase 1. `vidData` holds its value at all other times, and `vidValid` is 0 otherwise.
- R7: If a CPU read was strobed in phase 1, `cpuDataIn` shows `sramRdData` during the following phase 2. Through phases 0 and 1 of the next T state, `cpuDataIn` keeps that captured value.
- R8: With bypass high:
  - `cpuWait` is 0 and `sramAddr` equals `cpuAddr`.
  - `sramCe` equals `cpuRead | cpuWrite` and `sramWe` equals `cpuWrite`.
  - `cpuDataIn` equals `sramRdData`.
  - `vidValid` is 0.
- R9: While reset is asserted (active low, asynchronous), `cpuWait` is 1, `vidValid` is 0, and `vidData` and `cpuDataIn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, up to three times the CPU rate |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassEn | input | 1 | 1 turns the schedule off (wait low, direct CPU access) |
| cpuAddr | input | ADDR_W | CPU address |
| cpuDataOut | input | DATA_W | CPU write data |
| cpuRead | input | 1 | CPU read request |
| cpuWrite | input | 1 | CPU write request |
| cpuWait | output | 1 | Wait input of the core |
| cpuDataIn | output | DATA_W | Read data returned to the CPU |
| vidAddr | input | ADDR_W | Video reader address |
| vidReq | input | 1 | Video read request, honoured in phase 0 |
| vidData | output | DATA_W | Registered video read data |
| vidValid | output | 1 | One-cycle pulse marking new `vidData` |
| sramAddr | output | ADDR_W | SRAM address |
| sramWrData | output | DATA_W | SRAM write data |
| sramRdData | input | DATA_W | SRAM read data, one cycle after the strobe |
| sramCe | output | 1 | SRAM chip enable |
| sramWe | output | 1 | SRAM write enable |

## Verification
The SRAM strobes, address and `cpuWait` are combinational from the phase and the inputs, so they are due in the same cycle. Video data is due two edges after a phase-0 request: the SRAM registers the request at the first edge and the block captures the data at the second, so it appears in phase 2. CPU read data is due in the phase 2 that follows the phase-1 strobe, then held for the two phases after it. The bench keeps a behavioural SRAM and a phase-tracking reference, updates both at each rising edge, drives inputs just after that edge, and compares every output at the falling edge, when all of these delays have settled.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  localparam int PHASE_CNT = 3;
  localparam int PHASE_W   = $clog2(PHASE_CNT);

  typedef logic [PHASE_W-1:0] phaseT;

  // Phase ownership: the video slot comes first, then the CPU read, then the CPU write.
  localparam phaseT PH_VID = phaseT'(0);
  localparam phaseT PH_RD  = phaseT'(1);
  localparam phaseT PH_WR  = phaseT'(PHASE_CNT - 1);

  typedef struct packed {
    logic bypass;      // schedule disabled
    logic selVid;      // address mux picks the video address
    logic vidRdStb;    // video read strobe this cycle
    logic cpuRdStb;    // CPU read strobe this cycle
    logic cpuWrStb;    // CPU write strobe this cycle
    logic vidCapture;  // SRAM data this cycle belongs to the video reader
    logic cpuCapture;  // SRAM data this cycle belongs to the CPU
    logic holdWait;    // keep the core stalled
  } stbT;
endpackage

// File: rtl/tps_ctrl.sv
`timescale 1ns/1ps
module tps_ctrl
  import tps_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  bypassEn,
  input  logic  cpuRead,
  input  logic  cpuWrite,
  input  logic  vidReq,
  output phaseT phase,
  output stbT   stb
);
  logic vidCapQ;
  logic cpuCapQ;
  logic lastPhase;

  assign lastPhase = (phase == PH_WR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_VID;
      vidCapQ <= 1'b0;
      cpuCapQ <= 1'b0;
    end else begin
      phase   <= lastPhase ? PH_VID : phaseT'(phase + 1'b1);
      vidCapQ <= !bypassEn && (phase == PH_VID) && vidReq;
      cpuCapQ <= !bypassEn && (phase == PH_RD) && cpuRead;
    end
  end

  always_comb begin
    stb.bypass     = bypassEn;
    stb.selVid     = !bypassEn && (phase == PH_VID);
    stb.vidRdStb   = stb.selVid && vidReq;
    stb.cpuRdStb   = bypassEn ? cpuRead  : ((phase == PH_RD) && cpuRead);
    stb.cpuWrStb   = bypassEn ? cpuWrite : (lastPhase && cpuWrite);
    stb.vidCapture = vidCapQ && !bypassEn;
    stb.cpuCapture = cpuCapQ && !bypassEn;
    stb.holdWait   = !bypassEn && !lastPhase;
  end

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WR) |=> (phase == PH_VID));
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_WR) |=> (phase == phaseT'($past(phase) + 1'b1)));
endmodule

// File: rtl/tps_datapath.sv
`timescale 1ns/1ps
module tps_datapath
  import tps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stbT               stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuDataOut,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic [DATA_W-1:0] sramRdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWrData,
  output logic              sramCe,
  output logic              sramWe,
  output logic              cpuWait,
  output logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] vidData,
  output logic              vidValid
);
  logic [DATA_W-1:0] vidDataQ;
  logic              vidValidQ;
  logic [DATA_W-1:0] cpuHoldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidDataQ  <= '0;
      vidValidQ <= 1'b0;
      cpuHoldQ  <= '0;
    end else begin
      if (stb.vidCapture) vidDataQ <= sramRdData;
      vidValidQ <= stb.vidCapture;
      if (stb.cpuCapture) cpuHoldQ <= sramRdData;
    end
  end

  always_comb begin
    sramAddr   = stb.selVid ? vidAddr : cpuAddr;
    sramWrData = cpuDataOut;
    sramCe     = stb.vidRdStb | stb.cpuRdStb | stb.cpuWrStb;
    sramWe     = stb.cpuWrStb;
    cpuWait    = stb.holdWait;
    cpuDataIn  = (stb.bypass || stb.cpuCapture) ? sramRdData : cpuHoldQ;
    vidData    = vidDataQ;
    vidValid   = vidValidQ && !stb.bypass;
  end

  assert_vid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    vidValid |=> !vidValid);
endmodule

// File: rtl/tri_phase_sram_sched.sv
`timescale 1ns/1ps
module tri_phase_sram_sched
  import tps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuDataOut,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  output logic              cpuWait,
  output logic [DATA_W-1:0] cpuDataIn,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic              vidReq,
  output logic [DATA_W-1:0] vidData,
  output logic              vidValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWrData,
  input  logic [DATA_W-1:0] sramRdData,
  output logic              sramCe,
  output logic              sramWe
);
  phaseT phase;
  stbT   stb;

  tps_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bypassEn (bypassEn),
    .cpuRead  (cpuRead),
    .cpuWrite (cpuWrite),
    .vidReq   (vidReq),
    .phase    (phase),
    .stb      (stb)
  );

  tps_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cpuAddr    (cpuAddr),
    .cpuDataOut (cpuDataOut),
    .vidAddr    (vidAddr),
    .sramRdData (sramRdData),
    .sramAddr   (sramAddr),
    .sramWrData (sramWrData),
    .sramCe     (sramCe),
    .sramWe     (sramWe),
    .cpuWait    (cpuWait),
    .cpuDataIn  (cpuDataIn),
    .vidData    (vidData),
    .vidValid   (vidValid)
  );

  assert_we_late_R5: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (bypassEn || phase == PH_WR));
  assert_wait_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassEn && !cpuWait) |=> (bypassEn || cpuWait));
  assert_cpu_data_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassEn && !$past(bypassEn) && phase != PH_WR) |-> (cpuDataIn == $past(cpuDataIn)));
  assert_bypass_no_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    bypassEn |-> !cpuWait);
endmodule

// File: tb/tb_tri_phase_sram_sched.sv
`timescale 1ns/1ps
module tb_tri_phase_sram_sched;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypassEn = 1'b0;
  logic [AW-1:0] cpuAddr = '0, vidAddr = '0, sramAddr;
  logic [DW-1:0] cpuDataOut = '0, cpuDataIn, vidData, sramWrData;
  logic [DW-1:0] sramRdData = '0;
  logic cpuRead = 1'b0, cpuWrite = 1'b0, vidReq = 1'b0;
  logic cpuWait, vidValid, sramCe, sramWe;

  tri_phase_sram_sched #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .bypassEn(bypassEn),
    .cpuAddr(cpuAddr), .cpuDataOut(cpuDataOut), .cpuRead(cpuRead), .cpuWrite(cpuWrite),
    .cpuWait(cpuWait), .cpuDataIn(cpuDataIn),
    .vidAddr(vidAddr), .vidReq(vidReq), .vidData(vidData), .vidValid(vidValid),
    .sramAddr(sramAddr), .sramWrData(sramWrData), .sramRdData(sramRdData),
    .sramCe(sramCe), .sramWe(sramWe)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural SRAM with one-cycle read latency
  logic [DW-1:0] mem [0:(1<<AW)-1];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 5);
  always @(posedge clk) begin
    if (sramCe) begin
      if (sramWe) mem[sramAddr] <= sramWrData;
      else sramRdData <= mem[sramAddr];
    end
  end

  // Reference: which phase the triple is in, and what each reader is owed
  int mPh;
  bit mVidFresh, mCpuFresh, mVidValid;
  logic [DW-1:0] mVidData, mCpuHold;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh <= 0; mVidFresh <= 0; mCpuFresh <= 0; mVidValid <= 0;
      mVidData <= '0; mCpuHold <= '0;
    end else begin
      mPh <= (mPh == 2) ? 0 : mPh + 1;
      mVidFresh <= !bypassEn && mPh == 0 && vidReq;
      mCpuFresh <= !bypassEn && mPh == 1 && cpuRead;
      if (mVidFresh && !bypassEn) mVidData <= sramRdData;
      mVidValid <= mVidFresh && !bypassEn;
      if (mCpuFresh && !bypassEn) mCpuHold <= sramRdData;
    end
  end

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      string tg;
      logic eWait, eCe, eWe;
      logic [AW-1:0] eAddr;
      logic [DW-1:0] eCpu;
      if (!rstN) tg = "R9";
      else if (bypassEn) tg = "R8";
      else if (mPh == 0) tg = "R3";
      else if (mPh == 1) tg = "R4";
      else tg = "R5";
      if (bypassEn && rstN) begin
        eWait = 1'b0; eAddr = cpuAddr; eCe = cpuRead | cpuWrite; eWe = cpuWrite;
      end else if (mPh == 0) begin
        eWait = 1'b1; eAddr = bypassEn ? cpuAddr : vidAddr;
        eCe = bypassEn ? (cpuRead | cpuWrite) : vidReq;
        eWe = bypassEn ? cpuWrite : 1'b0;
      end else if (mPh == 1) begin
        eWait = 1'b1; eAddr = cpuAddr; eCe = cpuRead; eWe = 1'b0;
      end else begin
        eWait = 1'b0; eAddr = cpuAddr; eCe = cpuWrite; eWe = cpuWrite;
      end
      if (!rstN && bypassEn) eWait = 1'b0;
      eCpu = (bypassEn || mCpuFresh) ? sramRdData : mCpuHold;
      chk(bypassEn ? "R8" : "R1 R2", "cpuWait", 32'(cpuWait), 32'(eWait));
      chk(tg, "sramAddr", 32'(sramAddr), 32'(eAddr));
      chk(tg, "sramCe", 32'(sramCe), 32'(eCe));
      chk(tg, "sramWe", 32'(sramWe), 32'(eWe));
      chk("R5", "sramWrData", 32'(sramWrData), 32'(cpuDataOut));
      chk(bypassEn ? "R8" : "R6", "vidValid", 32'(vidValid), 32'(mVidValid && !bypassEn));
      chk("R6", "vidData", 32'(vidData), 32'(mVidData));
      chk(bypassEn ? "R8" : "R7", "cpuDataIn", 32'(cpuDataIn), 32'(eCpu));
    end
  end

  task automatic drive_random(int cycles, bit byp);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); #1;
      bypassEn   = byp;
      cpuAddr    = AW'($urandom % 16);
      vidAddr    = AW'($urandom % 16);
      cpuDataOut = DW'($urandom);
      cpuRead    = $urandom % 2;
      cpuWrite   = !cpuRead && ($urandom % 3 == 0);
      vidReq     = $urandom % 2;
    end
  endtask

  initial begin
    // R9: outputs held in their reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "cpuWait in reset", 32'(cpuWait), 32'd1);
    chk("R9", "vidValid in reset", 32'(vidValid), 32'd0);
    chk("R9", "cpuDataIn in reset", 32'(cpuDataIn), 32'd0);
    chk("R9", "vidData in reset", 32'(vidData), 32'd0);
    @(posedge clk); #1 rstN = 1'b1;
    // R1: after release the wait pattern is 1,1,0
    @(negedge clk); chk("R1", "wait phase0", 32'(cpuWait), 32'd1);
    @(negedge clk); chk("R1", "wait phase1", 32'(cpuWait), 32'd1);
    @(negedge clk); chk("R1", "wait phase2", 32'(cpuWait), 32'd0);
    drive_random(900, 1'b0);
    // Mid-run reset lands in an arbitrary phase
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    drive_random(400, 1'b0);
    // R8: bypass run
    drive_random(300, 1'b1);
    drive_random(400, 1'b0);
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule